// File: doc/BRIEF.md
# Host Command Register Mode Tracker

This block sits beside a 16-bit command register that a host writes and a local controller services. The meaning of a written value depends on the layout the register is currently in. There are three layouts: control commands, self tests and remote debug operations. The block keeps track of the current layout. It decodes each host write into a single registered strobe with an index, and it rejects requests that do not select exactly one operation. It clears the register when the local side reports that the operation has finished. It does not carry out the commands or tests, and it does not hold their parameters.

Outside debug layout, bit 15 of each write picks the layout. A write with bit 15 clear is a control command. A write with bit 15 set is a self test. The control command on bit 3 moves the tracker into debug layout, and it stays there until a debug write asks for exit, proceed or start-program. Bit 14 forces a hard reset from any layout. On completion of a self test, the local failure bitmap is captured into a result word whose bits line up with the test-select bits.

Top module: `hcr_mode_tracker`

## Requirements
- R1: After reset, cmd_reg is 0, mode is 0 (control), test_result is 0 and every strobe output is low.
- R2: In control or test layout, a write with bits 15 and 14 clear and exactly one bit set among bits 9:0 gives cmd_stb for one cycle after the write edge. op_idx carries the set bit's position and cmd_reg takes the written value. Bits 13:10 are ignored.
- R3: In control or test layout, a write with bit 15 set, bit 14 clear and exactly one bit set among bits 10:0 gives test_stb with op_idx equal to that position, and mode becomes 1 (test). Bits 13:11 are ignored.
- R4: A write whose select field has zero bits or more than one bit set raises req_err for one cycle. It gives no other strobe and leaves cmd_reg and mode unchanged.
- R5: The control command on bit 3 sets mode to 2 (debug). Completions do not leave debug layout.
- R6: In debug layout, the select field is bits {15,4,3,2,1,0}, and bits 13:5 are ignored. A write that sets exactly one of these bits gives dbg_stb with op_idx equal to one of the following codes:
  - 0: open memory (bit 0)
  - 1: open register (bit 1)
  - 2: deposit (bit 2)
  - 3: start program (bit 3)
  - 4: proceed (bit 4)
  - 5: exit (bit 15)
- R7: Codes 3, 4 and 5 return mode to 0. Codes 0, 1 and 2 keep mode at 2.
- R8: A write with bit 14 set, in any layout, gives hard_rst for one cycle. It clears cmd_reg and test_result and sets mode to 0, and it gives no other strobe.
- R9: When local_done is high with no host write, cmd_reg becomes 0 on the next edge. If mode was 1, mode returns to 0.
- R10: A completion in test layout loads test_result with the failure bitmap in bits 10:0 (bit n fails test n) and zeros in bits 15:11.
- R11: A host write and local_done in the same cycle: the write is taken and the completion is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write value |
| local_done | input | 1 | Local side finished the current operation |
| fail_map | input | 11 | Failure bitmap of the finished test |
| cmd_reg | output | 16 | Current register contents |
| mode | output | 2 | Layout: 0 control, 1 test, 2 debug |
| cmd_stb | output | 1 | Control command accepted |
| test_stb | output | 1 | Self test accepted |
| dbg_stb | output | 1 | Debug operation accepted |
| op_idx | output | 4 | Index of the accepted command, test or debug code |
| hard_rst | output | 1 | Hard reset request |
| req_err | output | 1 | Illegal multi-bit or empty request |
| test_result | output | 16 | Result word of the last finished test |

## Verification
The decoder is driven with single-bit selects at the lowest and highest positions of each field, and with the same selects while ignored high bits are set. These cases show that the field width and the masking are correct. It is also driven with empty and two-bit fields, including a two-bit field that spans bit 15 in debug layout, so that the one-hot test is separated from the plain field decode. Sequences walk through debug entry and each of the three ways out, and interleave completions. This shows that sticky debug layout differs from the per-write choice made by bit 15. Directed cases cover hard reset from each layout, and a write and a completion in the same cycle.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  typedef enum logic [1:0] {
    MODE_CTRL = 2'd0,
    MODE_TEST = 2'd1,
    MODE_DBG  = 2'd2
  } hcr_mode_e;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_CMD  = 3'd1,
    K_TEST = 3'd2,
    K_DBG  = 3'd3,
    K_HRST = 3'd4,
    K_ERR  = 3'd5
  } hcr_kind_e;

  localparam int unsigned LAYOUT_BIT  = 15;
  localparam int unsigned HRST_BIT    = 14;
  localparam int unsigned DBG_ENTER   = 3;
  localparam int unsigned DBG_LOW_N   = 5;
  localparam int unsigned DBG_SEL_N   = DBG_LOW_N + 1;
  localparam int unsigned DBG_RESUME0 = 3;
endpackage

// File: rtl/hcr_decode.sv
module hcr_decode
  import hcr_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned CMD_N  = 10,
  parameter int unsigned TEST_N = 11,
  parameter int unsigned IDXW   = $clog2(TEST_N)
) (
  input  hcr_mode_e        mode_i,
  input  logic [DW-1:0]    wdata_i,
  output hcr_kind_e        kind_o,
  output logic [IDXW-1:0]  idx_o,
  output hcr_mode_e        mode_o
);
  logic [CMD_N-1:0]     cmd_f;
  logic [TEST_N-1:0]    test_f;
  logic [DBG_SEL_N-1:0] dbg_f;
  logic [IDXW-1:0]      cmd_ix, test_ix, dbg_ix;

  assign cmd_f  = wdata_i[CMD_N-1:0];
  assign test_f = wdata_i[TEST_N-1:0];
  assign dbg_f  = {wdata_i[LAYOUT_BIT], wdata_i[DBG_LOW_N-1:0]};

  always_comb begin
    cmd_ix = '0;
    for (int i = CMD_N - 1; i >= 0; i--)
      if (cmd_f[i]) cmd_ix = IDXW'(i);
    test_ix = '0;
    for (int i = TEST_N - 1; i >= 0; i--)
      if (test_f[i]) test_ix = IDXW'(i);
    dbg_ix = '0;
    for (int i = DBG_SEL_N - 1; i >= 0; i--)
      if (dbg_f[i]) dbg_ix = IDXW'(i);
  end

  always_comb begin
    kind_o = K_ERR;
    idx_o  = '0;
    mode_o = mode_i;
    if (wdata_i[HRST_BIT]) begin
      kind_o = K_HRST;
      mode_o = MODE_CTRL;
    end else if (mode_i == MODE_DBG) begin
      if ($countones(dbg_f) == 1) begin
        kind_o = K_DBG;
        idx_o  = dbg_ix;
        if (dbg_ix >= IDXW'(DBG_RESUME0)) mode_o = MODE_CTRL;
      end
    end else if (wdata_i[LAYOUT_BIT]) begin
      if ($countones(test_f) == 1) begin
        kind_o = K_TEST;
        idx_o  = test_ix;
        mode_o = MODE_TEST;
      end
    end else begin
      if ($countones(cmd_f) == 1) begin
        kind_o = K_CMD;
        idx_o  = cmd_ix;
        mode_o = (cmd_ix == IDXW'(DBG_ENTER)) ? MODE_DBG : MODE_CTRL;
      end
    end
  end
endmodule

// File: rtl/hcr_state.sv
module hcr_state
  import hcr_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned TEST_N = 11,
  parameter int unsigned IDXW   = $clog2(TEST_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              done_i,
  input  logic [TEST_N-1:0] fail_i,
  input  hcr_kind_e         kind_i,
  input  logic [IDXW-1:0]   idx_i,
  input  hcr_mode_e         dmode_i,
  output hcr_mode_e         mode_q,
  output logic [DW-1:0]     reg_q,
  output logic [DW-1:0]     res_q,
  output logic              cmd_q,
  output logic              test_q,
  output logic              dbg_q,
  output logic              hrst_q,
  output logic              err_q,
  output logic [IDXW-1:0]   idx_q
);
  hcr_mode_e       mode_n;
  logic [DW-1:0]   reg_n, res_n;
  logic            cmd_n, test_n, dbg_n, hrst_n, err_n;
  logic [IDXW-1:0] idx_n;

  always_comb begin
    mode_n = mode_q;
    reg_n  = reg_q;
    res_n  = res_q;
    idx_n  = idx_q;
    cmd_n  = 1'b0;
    test_n = 1'b0;
    dbg_n  = 1'b0;
    hrst_n = 1'b0;
    err_n  = 1'b0;
    if (wr_i) begin
      unique case (kind_i)
        K_HRST: begin
          hrst_n = 1'b1;
          reg_n  = '0;
          res_n  = '0;
          mode_n = MODE_CTRL;
        end
        K_CMD, K_TEST, K_DBG: begin
          cmd_n  = (kind_i == K_CMD);
          test_n = (kind_i == K_TEST);
          dbg_n  = (kind_i == K_DBG);
          idx_n  = idx_i;
          reg_n  = wdata_i;
          mode_n = dmode_i;
        end
        default: err_n = 1'b1;
      endcase
    end else if (done_i) begin
      reg_n = '0;
      if (mode_q == MODE_TEST) begin
        res_n  = {{(DW-TEST_N){1'b0}}, fail_i};
        mode_n = MODE_CTRL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_CTRL;
      reg_q  <= '0;
      res_q  <= '0;
      idx_q  <= '0;
      cmd_q  <= 1'b0;
      test_q <= 1'b0;
      dbg_q  <= 1'b0;
      hrst_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      reg_q  <= reg_n;
      res_q  <= res_n;
      idx_q  <= idx_n;
      cmd_q  <= cmd_n;
      test_q <= test_n;
      dbg_q  <= dbg_n;
      hrst_q <= hrst_n;
      err_q  <= err_n;
    end
  end

  // R4: at most one outcome strobe per cycle
  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_q, test_q, dbg_q, hrst_q, err_q}));

  // R4: a rejected request leaves the register untouched
  a_r4_err_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(reg_q));

  // R8: hard reset from any layout
  a_r8_hard_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i[HRST_BIT]) |=> (hrst_q && reg_q == '0 && mode_q == MODE_CTRL));

  // R9: completion without a write clears the register
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && done_i) |=> (reg_q == '0));

  // R5: debug layout is sticky across idle cycles and completions
  a_r5_debug_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && mode_q == MODE_DBG) |=> (mode_q == MODE_DBG));

  // R10: upper bits of the result word stay zero
  a_r10_result_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q[DW-1:TEST_N] == '0));
endmodule

// File: rtl/hcr_mode_tracker.sv
module hcr_mode_tracker
  import hcr_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned CMD_N  = 10,
  parameter int unsigned TEST_N = 11,
  parameter int unsigned IDXW   = $clog2(TEST_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DW-1:0]     host_wdata,
  input  logic              local_done,
  input  logic [TEST_N-1:0] fail_map,
  output logic [DW-1:0]     cmd_reg,
  output logic [1:0]        mode,
  output logic              cmd_stb,
  output logic              test_stb,
  output logic              dbg_stb,
  output logic [IDXW-1:0]   op_idx,
  output logic              hard_rst,
  output logic              req_err,
  output logic [DW-1:0]     test_result
);
  hcr_mode_e       cur_mode, dec_mode;
  hcr_kind_e       dec_kind;
  logic [IDXW-1:0] dec_idx;

  hcr_decode #(.DW(DW), .CMD_N(CMD_N), .TEST_N(TEST_N), .IDXW(IDXW)) u_decode (
    .mode_i  (cur_mode),
    .wdata_i (host_wdata),
    .kind_o  (dec_kind),
    .idx_o   (dec_idx),
    .mode_o  (dec_mode)
  );

  hcr_state #(.DW(DW), .TEST_N(TEST_N), .IDXW(IDXW)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (host_wr),
    .wdata_i (host_wdata),
    .done_i  (local_done),
    .fail_i  (fail_map),
    .kind_i  (dec_kind),
    .idx_i   (dec_idx),
    .dmode_i (dec_mode),
    .mode_q  (cur_mode),
    .reg_q   (cmd_reg),
    .res_q   (test_result),
    .cmd_q   (cmd_stb),
    .test_q  (test_stb),
    .dbg_q   (dbg_stb),
    .hrst_q  (hard_rst),
    .err_q   (req_err),
    .idx_q   (op_idx)
  );

  assign mode = cur_mode;
endmodule

// File: tb/hcr_mode_tracker_bench.sv
module hcr_mode_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        local_done = 1'b0;
  logic [10:0] fail_map = '0;
  logic [15:0] cmd_reg, test_result;
  logic [1:0]  mode;
  logic        cmd_stb, test_stb, dbg_stb, hard_rst, req_err;
  logic [3:0]  op_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hcr_mode_tracker u_hcr_mode_tracker (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .local_done(local_done), .fail_map(fail_map), .cmd_reg(cmd_reg), .mode(mode),
    .cmd_stb(cmd_stb), .test_stb(test_stb), .dbg_stb(dbg_stb), .op_idx(op_idx),
    .hard_rst(hard_rst), .req_err(req_err), .test_result(test_result)
  );

  // vector: wdata, expected kind (0 none,1 cmd,2 test,3 dbg,4 hrst,5 err), index, mode after
  localparam int NV = 21;
  localparam logic [24:0] VEC [NV] = '{
    {16'h0001, 3'd1, 4'd0,  2'd0},  // R2 lowest command
    {16'h0200, 3'd1, 4'd9,  2'd0},  // R2 highest command
    {16'h0003, 3'd5, 4'd0,  2'd0},  // R4 two bits
    {16'h0000, 3'd5, 4'd0,  2'd0},  // R4 empty
    {16'h8400, 3'd2, 4'd10, 2'd1},  // R3 highest test
    {16'h8000, 3'd5, 4'd0,  2'd0},  // R4 empty test field
    {16'h9001, 3'd2, 4'd0,  2'd1},  // R3 bit 12 ignored
    {16'h2404, 3'd1, 4'd2,  2'd0},  // R2 bits 13,10 ignored
    {16'h0008, 3'd1, 4'd3,  2'd2},  // R5 enter debug
    {16'h0004, 3'd3, 4'd2,  2'd2},  // R6 deposit
    {16'h0002, 3'd3, 4'd1,  2'd2},  // R6 open register
    {16'h0001, 3'd3, 4'd0,  2'd2},  // R6 open memory
    {16'h0006, 3'd5, 4'd0,  2'd2},  // R4 two debug bits
    {16'h8001, 3'd5, 4'd0,  2'd2},  // R4 bit 15 plus bit 0 in debug
    {16'h0010, 3'd3, 4'd4,  2'd0},  // R7 proceed
    {16'h0008, 3'd1, 4'd3,  2'd2},  // R5 re-enter
    {16'h0020, 3'd5, 4'd0,  2'd2},  // R6 bit 5 ignored -> empty
    {16'h0008, 3'd3, 4'd3,  2'd0},  // R7 start program
    {16'h0008, 3'd1, 4'd3,  2'd2},  // R5 re-enter
    {16'h8000, 3'd3, 4'd5,  2'd0},  // R7 exit
    {16'h4001, 3'd4, 4'd0,  2'd0}   // R8 hard reset
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] obs_kind();
    if (cmd_stb)  return 3'd1;
    if (test_stb) return 3'd2;
    if (dbg_stb)  return 3'd3;
    if (hard_rst) return 3'd4;
    if (req_err)  return 3'd5;
    return 3'd0;
  endfunction

  task automatic do_write(input logic [15:0] d, input logic with_done);
    @(negedge clk);
    host_wr = 1'b1; host_wdata = d; local_done = with_done;
    @(negedge clk);
    host_wr = 1'b0; local_done = 1'b0;
  endtask

  task automatic do_done();
    @(negedge clk);
    local_done = 1'b1;
    @(negedge clk);
    local_done = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cmd_reg", cmd_reg, 0);
    chk("R1 mode", mode, 0);
    chk("R1 strobes", obs_kind(), 0);
    chk("R1 test_result", test_result, 0);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] d;
      logic [2:0]  k;
      d = VEC[v][24:9];
      k = VEC[v][8:6];
      do_write(d, 1'b0);
      chk($sformatf("R2-R8 kind vec%0d", v), obs_kind(), k);
      if (k >= 3'd1 && k <= 3'd3)
        chk($sformatf("R2 op_idx vec%0d", v), op_idx, VEC[v][5:2]);
      chk($sformatf("R5 mode vec%0d", v), mode, VEC[v][1:0]);
      chk($sformatf("R4 cmd_reg vec%0d", v), cmd_reg, (k >= 3'd1 && k <= 3'd3) ? d : 16'h0);
      do_done();
      chk($sformatf("R9 cleared vec%0d", v), cmd_reg, 0);
      chk($sformatf("R9 strobe low vec%0d", v), obs_kind(), 0);
      if (VEC[v][1:0] == 2'd1) chk($sformatf("R9 test exits vec%0d", v), mode, 0);
    end

    // R10 result word capture
    fail_map = 11'h555;
    do_write(16'h8010, 1'b0);
    chk("R3 test idx", op_idx, 4);
    chk("R10 result before done", test_result, 0);
    do_done();
    chk("R10 result word", test_result, 16'h0555);
    chk("R10 mode back", mode, 0);
    fail_map = 11'h7FF;
    do_done();
    chk("R10 completion outside test", test_result, 16'h0555);

    // R11 write and done together
    do_write(16'h0040, 1'b1);
    chk("R11 strobe", obs_kind(), 1);
    chk("R11 reg kept", cmd_reg, 16'h0040);
    do_done();

    // R8 hard reset in test layout with pending operation
    do_write(16'h8002, 1'b0);
    chk("R3 mode test", mode, 1);
    do_write(16'h4000, 1'b0);
    chk("R8 strobe", obs_kind(), 4);
    chk("R8 reg", cmd_reg, 0);
    chk("R8 mode", mode, 0);
    chk("R8 result cleared", test_result, 0);

    // R8 hard reset from debug layout
    do_write(16'h0008, 1'b0);
    do_done();
    chk("R5 debug after done", mode, 2);
    do_write(16'hC004, 1'b0);
    chk("R8 dbg strobe", obs_kind(), 4);
    chk("R8 dbg mode", mode, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule